// File: doc/BRIEF.md
# Transceiver Operating-Mode Controller

This block decides which of four operating modes a single-wire bus transceiver is in: unpowered, standby, normal and sleep. It watches a supply-good indication (a power-on-reset flag), the enable pin from the host and a wake-up event strobe that also carries the event type (local switch or remote bus activity). From the mode it drives the transceiver enable, the high-side switch that powers an external regulator, the selection of the bus termination, and how the receive and transmit pads are configured.

The enable pin is filtered in both directions by two programmable timers, one for the high level and one for the low level. Each one counts consecutive clock samples and starts over on any change of the pin. In standby the receive and transmit pads report which wake-up source caused the entry. These pads are released as soon as the enable pin is seen high, before the high filter runs out. A wake-up that arrives while the low filter is counting down in normal mode is honoured, and the block goes to standby.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While `rst` or `por_i` is sampled high, the next state is unpowered: `mode_o` = 00, `trx_en_o` = 0, `inh_en_o` = 0, `term_o` = 00 (floating), `rxd_low_o` = 0, `txd_strong_o` = 0. A supply drop moves the block to this state from any other mode.
- R2: In unpowered with `por_i` low, the next edge enters standby (`mode_o` = 01) with `rxd_low_o` = 0 and `txd_strong_o` = 0. Standby drives `inh_en_o` = 1, `trx_en_o` = 0 and `term_o` = 01 (resistor pull-up).
- R3: In sleep, a `wake_i` pulse moves the block to standby on the next edge with `rxd_low_o` = 1 and `txd_strong_o` equal to `wake_local_i`, where 1 means a local wake-up and 0 means a remote one.
- R4: In standby, `wake_i` pulses of either type change neither `mode_o` nor `rxd_low_o` / `txd_strong_o`.
- R5: In standby, the first edge that samples `en_i` high clears `rxd_low_o` and `txd_strong_o`, even though the high filter has not yet expired.
- R6: In standby or sleep, when `en_i` is sampled high on `t_enable_i` consecutive edges (a limit of 0 acts as 1), the block enters normal (`mode_o` = 10) at the last of those edges. Normal drives `trx_en_o` = 1, `inh_en_o` = 1 and `term_o` = 01.
- R7: In normal, when `en_i` is sampled low on `t_disable_i` consecutive edges (a limit of 0 acts as 1), the block enters sleep (`mode_o` = 11) at the last of those edges. Sleep drives `trx_en_o` = 0, `inh_en_o` = 0 and `term_o` = 10 (current source).
- R8: In normal, a `wake_i` pulse sampled while `en_i` is low moves the block to standby with the wake-up pad coding of R3. A `wake_i` pulse sampled while `en_i` is high has no effect.
- R9: An enable pulse shorter than its filter limit causes no mode change. Any change of `en_i` restarts the filter count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Supply below power-on-reset level |
| en_i | input | 1 | Host enable pin level |
| wake_i | input | 1 | One-cycle wake-up event strobe |
| wake_local_i | input | 1 | Wake-up type: 1 local, 0 remote |
| t_enable_i | input | CNT_W | Consecutive high samples needed to enter normal |
| t_disable_i | input | CNT_W | Consecutive low samples needed to enter sleep |
| mode_o | output | 2 | 00 unpowered, 01 standby, 10 normal, 11 sleep |
| trx_en_o | output | 1 | Transceiver enable |
| inh_en_o | output | 1 | High-side switch enable |
| term_o | output | 2 | Termination: 00 floating, 01 resistor, 10 current source |
| rxd_low_o | output | 1 | Receive pad pulled low (else high impedance) |
| txd_strong_o | output | 1 | Transmit pad strong pull-down (else weak) |

## Verification
On every cycle the assertions check the single-step rules: supply loss forcing unpowered, power-up into standby with the pads released, sleep wake-ups coding the pads by type, the pads holding steady in standby while the enable pin stays low, the early release on a high enable sample, and normal mode staying put while the enable pin is high. The filter durations cannot be expressed as short properties because their limits are run-time inputs. The bench's reference model shows that a transition lands exactly on the T-th consecutive sample, that short pulses restart the count, and that a wake-up inside the sleep-entry window is honoured.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_STBY  = 2'b01,
        MODE_NORM  = 2'b10,
        MODE_SLEEP = 2'b11
    } mode_t;

    typedef enum logic [1:0] {
        TERM_FLOAT = 2'b00,
        TERM_RES   = 2'b01,
        TERM_CUR   = 2'b10
    } term_t;

    typedef struct packed {
        logic  trx_en;
        logic  inh_en;
        term_t term;
    } drive_t;

    function automatic drive_t mode_drive(input mode_t m);
        drive_t d;
        d.trx_en = 1'b0;
        d.inh_en = 1'b0;
        d.term   = TERM_FLOAT;
        case (m)
            MODE_STBY: begin
                d.inh_en = 1'b1;
                d.term   = TERM_RES;
            end
            MODE_NORM: begin
                d.trx_en = 1'b1;
                d.inh_en = 1'b1;
                d.term   = TERM_RES;
            end
            MODE_SLEEP: d.term = TERM_CUR;
            default: d.term = TERM_FLOAT;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lin_en_filter.sv
module lin_en_filter #(
    parameter int   CNT_W = 8,
    parameter logic POL   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             restart,
    input  logic             en_i,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_eff;
    logic             at_level;

    assign lim_eff  = (limit == '0) ? ONE : limit;
    assign at_level = active && (en_i == POL);
    assign fire     = at_level && ({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1} >= {1'b0, lim_eff});

    always_ff @(posedge clk) begin
        if (rst || restart || !at_level) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
    import lin_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  por_i,
    input  logic  en_i,
    input  logic  wake_i,
    input  logic  wake_local_i,
    input  logic  hi_fire,
    input  logic  lo_fire,
    output mode_t mode_q,
    output mode_t mode_nxt,
    output logic  rxd_low_q,
    output logic  txd_strong_q
);
    logic rxd_nxt;
    logic txd_nxt;

    always_comb begin
        mode_nxt = mode_q;
        rxd_nxt  = rxd_low_q;
        txd_nxt  = txd_strong_q;
        if (por_i) begin
            mode_nxt = MODE_OFF;
            rxd_nxt  = 1'b0;
            txd_nxt  = 1'b0;
        end else begin
            case (mode_q)
                MODE_OFF: begin
                    mode_nxt = MODE_STBY;
                    rxd_nxt  = 1'b0;
                    txd_nxt  = 1'b0;
                end
                MODE_STBY: begin
                    if (en_i) begin
                        rxd_nxt = 1'b0;
                        txd_nxt = 1'b0;
                    end
                    if (hi_fire) mode_nxt = MODE_NORM;
                end
                MODE_SLEEP: begin
                    if (wake_i) begin
                        mode_nxt = MODE_STBY;
                        rxd_nxt  = 1'b1;
                        txd_nxt  = wake_local_i;
                    end else if (hi_fire) begin
                        mode_nxt = MODE_NORM;
                    end
                end
                MODE_NORM: begin
                    if (!en_i && wake_i) begin
                        mode_nxt = MODE_STBY;
                        rxd_nxt  = 1'b1;
                        txd_nxt  = wake_local_i;
                    end else if (lo_fire) begin
                        mode_nxt = MODE_SLEEP;
                    end
                end
                default: mode_nxt = MODE_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q       <= MODE_OFF;
            rxd_low_q    <= 1'b0;
            txd_strong_q <= 1'b0;
        end else begin
            mode_q       <= mode_nxt;
            rxd_low_q    <= rxd_nxt;
            txd_strong_q <= txd_nxt;
        end
    end

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por_i,
    input  logic             en_i,
    input  logic             wake_i,
    input  logic             wake_local_i,
    input  logic [CNT_W-1:0] t_enable_i,
    input  logic [CNT_W-1:0] t_disable_i,
    output logic [1:0]       mode_o,
    output logic             trx_en_o,
    output logic             inh_en_o,
    output logic [1:0]       term_o,
    output logic             rxd_low_o,
    output logic             txd_strong_o
);
    mode_t  mode_q;
    mode_t  mode_nxt;
    logic   restart;
    logic   hi_active;
    logic   lo_active;
    logic   hi_fire;
    logic   lo_fire;
    drive_t drv;

    assign restart   = (mode_nxt != mode_q);
    assign hi_active = (mode_q == MODE_STBY) || (mode_q == MODE_SLEEP);
    assign lo_active = (mode_q == MODE_NORM);

    lin_en_filter #(.CNT_W(CNT_W), .POL(1'b1)) u_hi_filt (
        .clk(clk), .rst(rst), .active(hi_active), .restart(restart),
        .en_i(en_i), .limit(t_enable_i), .fire(hi_fire)
    );

    lin_en_filter #(.CNT_W(CNT_W), .POL(1'b0)) u_lo_filt (
        .clk(clk), .rst(rst), .active(lo_active), .restart(restart),
        .en_i(en_i), .limit(t_disable_i), .fire(lo_fire)
    );

    lin_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .por_i(por_i), .en_i(en_i),
        .wake_i(wake_i), .wake_local_i(wake_local_i),
        .hi_fire(hi_fire), .lo_fire(lo_fire),
        .mode_q(mode_q), .mode_nxt(mode_nxt),
        .rxd_low_q(rxd_low_o), .txd_strong_q(txd_strong_o)
    );

    assign drv      = mode_drive(mode_q);
    assign mode_o   = mode_q;
    assign trx_en_o = drv.trx_en;
    assign inh_en_o = drv.inh_en;
    assign term_o   = drv.term;

endmodule

// File: rtl/lin_mode_chk.sv
module lin_mode_chk (
    input logic       clk,
    input logic       rst,
    input logic       por_i,
    input logic       en_i,
    input logic       wake_i,
    input logic       wake_local_i,
    input logic [1:0] mode_o,
    input logic       rxd_low_o,
    input logic       txd_strong_o
);
    a_r1_supply_loss: assert property (@(posedge clk) disable iff (rst)
        por_i |=> (mode_o == 2'b00 && !rxd_low_o && !txd_strong_o));

    a_r2_power_up: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b00 && !por_i) |=> (mode_o == 2'b01 && !rxd_low_o && !txd_strong_o));

    a_r3_sleep_wake: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b11 && wake_i && !por_i) |=>
            (mode_o == 2'b01 && rxd_low_o && txd_strong_o == $past(wake_local_i)));

    a_r4_stby_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b01 && !en_i && !por_i) |=>
            (mode_o == 2'b01 && $stable(rxd_low_o) && $stable(txd_strong_o)));

    a_r5_early_release: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b01 && en_i && !por_i) |=> (!rxd_low_o && !txd_strong_o));

    a_r8_norm_en_high: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10 && en_i && !por_i) |=> (mode_o == 2'b10));

    a_r6_norm_needs_en: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'b10 && !en_i) |=> (mode_o != 2'b10));

endmodule

bind lin_mode_ctrl lin_mode_chk u_chk (
    .clk(clk), .rst(rst), .por_i(por_i), .en_i(en_i), .wake_i(wake_i),
    .wake_local_i(wake_local_i), .mode_o(mode_o),
    .rxd_low_o(rxd_low_o), .txd_strong_o(txd_strong_o)
);

// File: tb/lin_mode_ctrl_test.sv
module lin_mode_ctrl_test;
    localparam int CNT_W = 8;
    localparam int TEN   = 4;
    localparam int TDIS  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por_i = 1'b0;
    logic en_i = 1'b0;
    logic wake_i = 1'b0;
    logic wake_local_i = 1'b0;
    logic [CNT_W-1:0] t_enable_i = CNT_W'(TEN);
    logic [CNT_W-1:0] t_disable_i = CNT_W'(TDIS);
    logic [1:0] mode_o;
    logic trx_en_o, inh_en_o, rxd_low_o, txd_strong_o;
    logic [1:0] term_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string phase = "R1";

    lin_mode_ctrl #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .por_i(por_i), .en_i(en_i), .wake_i(wake_i),
        .wake_local_i(wake_local_i), .t_enable_i(t_enable_i), .t_disable_i(t_disable_i),
        .mode_o(mode_o), .trx_en_o(trx_en_o), .inh_en_o(inh_en_o), .term_o(term_o),
        .rxd_low_o(rxd_low_o), .txd_strong_o(txd_strong_o)
    );

    always #10 clk = ~clk;

    // behavioural reference: mode 0 off, 1 standby, 2 normal, 3 sleep
    int m_mode = 0;
    int m_rxd = 0;
    int m_txd = 0;
    int hi_run = 0;
    int lo_run = 0;

    function automatic int lim(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        int old;
        old = m_mode;
        if (rst || por_i) begin
            m_mode = 0; m_rxd = 0; m_txd = 0;
        end else if (m_mode == 0) begin
            m_mode = 1; m_rxd = 0; m_txd = 0;
        end else if (m_mode == 1) begin
            if (en_i) begin
                m_rxd = 0; m_txd = 0;
                hi_run++;
                if (hi_run >= lim(int'(t_enable_i))) m_mode = 2;
            end else hi_run = 0;
        end else if (m_mode == 3) begin
            if (en_i) hi_run++; else hi_run = 0;
            if (wake_i) begin
                m_mode = 1; m_rxd = 1; m_txd = wake_local_i ? 1 : 0;
            end else if (en_i && hi_run >= lim(int'(t_enable_i))) m_mode = 2;
        end else begin
            if (!en_i) begin
                lo_run++;
                if (wake_i) begin
                    m_mode = 1; m_rxd = 1; m_txd = wake_local_i ? 1 : 0;
                end else if (lo_run >= lim(int'(t_disable_i))) m_mode = 3;
            end else lo_run = 0;
        end
        if (m_mode != old || rst) begin
            hi_run = 0; lo_run = 0;
        end
    end

    task automatic fail_line(input string req, input string what, input int act, input int exp);
        bad++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            int e_trx, e_inh, e_term;
            e_trx = (m_mode == 2) ? 1 : 0;
            e_inh = (m_mode == 1 || m_mode == 2) ? 1 : 0;
            e_term = (m_mode == 0) ? 0 : (m_mode == 3) ? 2 : 1;
            total++;
            if (int'(mode_o) != m_mode || int'(rxd_low_o) != m_rxd || int'(txd_strong_o) != m_txd
                || int'(trx_en_o) != e_trx || int'(inh_en_o) != e_inh || int'(term_o) != e_term)
                fail_line(phase, "cycle mode/rxd/txd", int'({mode_o, rxd_low_o, txd_strong_o}),
                          (m_mode << 2) | (m_rxd << 1) | m_txd);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) fail_line(req, what, act, exp);
    endtask

    task automatic pulse_wake(input logic local_src);
        wake_i = 1'b1; wake_local_i = local_src;
        step(1);
        wake_i = 1'b0; wake_local_i = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        step(3);
        phase = "R1";
        check("R1", "reset mode", int'(mode_o), 0);
        check("R1", "reset term", int'(term_o), 0);
        check("R1", "reset inh", int'(inh_en_o), 0);
        rst = 1'b0; por_i = 1'b1;
        step(3);
        check("R1", "por holds off", int'(mode_o), 0);
        phase = "R2";
        por_i = 1'b0;
        step(1);
        check("R2", "power-up standby", int'(mode_o), 1);
        check("R2", "standby term", int'(term_o), 1);
        check("R2", "standby pads", int'({rxd_low_o, txd_strong_o}), 0);
        phase = "R9";
        en_i = 1'b1; step(TEN - 1); en_i = 1'b0; step(1);
        en_i = 1'b1; step(TEN - 1); en_i = 1'b0; step(2);
        check("R9", "short enable pulses", int'(mode_o), 1);
        phase = "R6";
        en_i = 1'b1; step(TEN - 1);
        check("R6", "one sample short", int'(mode_o), 1);
        step(1);
        check("R6", "normal entered", int'(mode_o), 2);
        check("R6", "trx on", int'(trx_en_o), 1);
        phase = "R8";
        pulse_wake(1'b1);
        check("R8", "wake ignored with en high", int'(mode_o), 2);
        phase = "R9";
        en_i = 1'b0; step(TDIS - 1); en_i = 1'b1; step(1);
        en_i = 1'b0; step(TDIS - 1); en_i = 1'b1; step(2);
        check("R9", "short low pulses", int'(mode_o), 2);
        phase = "R7";
        en_i = 1'b0; step(TDIS);
        check("R7", "sleep entered", int'(mode_o), 3);
        check("R7", "sleep term", int'(term_o), 2);
        check("R7", "sleep inh", int'(inh_en_o), 0);
        phase = "R3";
        step(2);
        pulse_wake(1'b1);
        check("R3", "local wake mode", int'(mode_o), 1);
        check("R3", "local wake pads", int'({rxd_low_o, txd_strong_o}), 3);
        phase = "R4";
        step(1);
        pulse_wake(1'b0);
        step(1);
        check("R4", "pads unchanged by wake", int'({rxd_low_o, txd_strong_o}), 3);
        phase = "R5";
        en_i = 1'b1; step(1);
        check("R5", "early release", int'({rxd_low_o, txd_strong_o}), 0);
        check("R5", "still standby", int'(mode_o), 1);
        step(TEN - 1);
        check("R6", "normal from standby", int'(mode_o), 2);
        phase = "R8";
        en_i = 1'b0; step(1);
        pulse_wake(1'b0);
        check("R8", "window wake mode", int'(mode_o), 1);
        check("R8", "remote wake pads", int'({rxd_low_o, txd_strong_o}), 2);
        phase = "R6";
        en_i = 1'b1; step(TEN);
        en_i = 1'b0; step(TDIS + 1);
        check("R7", "sleep again", int'(mode_o), 3);
        t_enable_i = '0;
        en_i = 1'b1; step(1);
        check("R6", "zero limit acts as one", int'(mode_o), 2);
        phase = "R1";
        por_i = 1'b1; step(1);
        check("R1", "supply loss from normal", int'(mode_o), 0);
        check("R1", "supply loss trx", int'(trx_en_o), 0);
        por_i = 1'b0; en_i = 1'b0; step(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule